// File: doc/BRIEF.md
# USB IN Endpoint Transfer Sequencer

This block runs one non-isochronous IN endpoint of a USB device controller. Firmware writes a byte count and a packet count for the transfer, then arms the endpoint with a clear-NAK strobe and an enable strobe. The packet engine signals each IN token from the host. For each token the block answers, one cycle later, with either a data packet from the transmit FIFO or a NAK handshake. Later the engine reports whether the host acknowledged the packet or timed out. On an acknowledge the byte and packet counters move down. On a timeout the FIFO read side is told to rewind.

Interrupts are sticky, and firmware clears them by writing ones to them. A transfer-complete interrupt fires when both counters reach zero. A short packet ends the transfer early and also clears the enable bit. An IN token that finds the FIFO empty and the packet count at zero raises its own interrupt. It still gets a NAK on the bus, but the endpoint NAK status bit is not set. A control endpoint also reports handshake timeouts. The block shows the FIFO-empty state and the free space in words, computed from the FIFO level, so firmware can check room before it writes.

The controller is a three-state machine:
- ST_IDLE waits for a token. A token that can be served moves it to ST_WAIT_HS. Any other token is answered with NAK, and the machine stays in ST_IDLE.
- ST_WAIT_HS waits for the handshake outcome. An acknowledge moves it to ST_COMMIT. A timeout returns it to ST_IDLE.
- ST_COMMIT updates the counters and always returns to ST_IDLE.

Top module: `in_ep_sequencer`

## Requirements
- R1: After reset, the endpoint is disabled, the NAK status is set, both counters are 0, all interrupt bits are 0, and no response pulse is active.
- R2: A load pulse copies the byte count and packet count into xfer_left and pkt_left. A token that is served produces, in the next cycle, a single rsp_send pulse with rsp_len = min(max packet size, xfer_left). Every token gets exactly one of rsp_send or rsp_nak in the next cycle.
- R3: When a full-size packet is acknowledged, xfer_left drops by rsp_len and pkt_left drops by 1. Both counters show the new values two cycles after the acknowledge.
- R4: When a packet shorter than max packet size is acknowledged, pkt_left is forced to 0, the transfer ends, the done interrupt (bit 0) is raised and the endpoint is disabled.
- R5: When an acknowledge brings both counters to 0, irq bit 0 (done) is set and ep_active is cleared in the same cycle. Before that point the endpoint stays enabled.
- R6: A token that arrives while fifo_level is 0 and pkt_left is 0 is answered with rsp_nak and sets irq bit 1 (empty token). It leaves ep_nak unchanged, so an armed endpoint keeps ep_nak at 0.
- R7: While the endpoint is disabled or ep_nak is 1, every token is answered with rsp_nak, no data is sent, and both counters stay unchanged.
- R8: A handshake timeout pulses fifo_rewind in the next cycle and leaves both counters unchanged. It sets irq bit 2 (timeout) only when cfg_ctrl_ep is 1.
- R9: An armed endpoint with pkt_left > 0 answers with rsp_nak and raises no interrupt when 4 × fifo_level bytes is less than the packet length it would send.
- R10: Writing 1 to a bit of fw_irq_clr clears that interrupt bit in the next cycle. Bits written with 0 keep their value.
- R11: txf_free equals FIFO_WORDS minus fifo_level, with a floor of 0. txf_empty is 1 exactly when fifo_level is 0.
- R12: With pkt_left > 0 and xfer_left = 0, a token is served with a zero-length packet (rsp_send, rsp_len = 0), even when the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Load pulse for the byte and packet counters |
| cfg_size | input | SIZE_W | Transfer size in bytes |
| cfg_pkts | input | PKT_W | Packet count |
| cfg_mps | input | MPS_W | Maximum packet size in bytes |
| cfg_ctrl_ep | input | 1 | 1 when the endpoint is a control endpoint |
| fw_enable | input | 1 | Pulse that enables the endpoint |
| fw_clear_nak | input | 1 | Pulse that clears the NAK status |
| fw_set_nak | input | 1 | Pulse that sets the NAK status (takes priority over clear) |
| fw_irq_clr | input | 3 | Write-one-to-clear mask for the interrupt bits |
| tok_in | input | 1 | IN token received (one-cycle pulse) |
| hs_ack | input | 1 | Host acknowledged the last data packet |
| hs_timeout | input | 1 | No handshake arrived for the last data packet |
| fifo_level | input | LVL_W | Words currently held in the transmit FIFO |
| rsp_send | output | 1 | Send a data packet (pulse) |
| rsp_nak | output | 1 | Answer with a NAK handshake (pulse) |
| rsp_len | output | MPS_W | Length of the packet being sent, in bytes |
| fifo_rewind | output | 1 | Rewind the FIFO read pointer (pulse) |
| ep_active | output | 1 | Endpoint enable status |
| ep_nak | output | 1 | Endpoint NAK status |
| xfer_left | output | SIZE_W | Bytes remaining in the transfer |
| pkt_left | output | PKT_W | Packets remaining in the transfer |
| irq | output | 3 | Sticky interrupts: bit 0 done, bit 1 empty token, bit 2 timeout |
| txf_empty | output | 1 | Transmit FIFO is empty |
| txf_free | output | LVL_W | Free space in the transmit FIFO, in words |

## Verification
The assertions assume the packet engine behaves as follows:
- It never delivers a token while a data packet is waiting for its handshake.
- It reports hs_ack or hs_timeout only after an rsp_send, and never both at once.
- cfg_mps and cfg_ctrl_ep stay fixed during a transfer.
- fw_enable does not coincide with the cycle in which a transfer completes.

The bench drives one token at a time, waits for the response pulse, and then gives exactly one handshake outcome. It reloads the counters and changes the configuration only while the machine is idle and no packet is outstanding.

// File: rtl/in_ep_pkg.sv
package in_ep_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WAIT_HS = 2'd1,
        ST_COMMIT  = 2'd2
    } seq_state_t;

    localparam int IRQ_N     = 3;
    localparam int IRQ_DONE  = 0;
    localparam int IRQ_EMPTY = 1;
    localparam int IRQ_TMO   = 2;

endpackage

// File: rtl/in_ep_counters.sv
module in_ep_counters #(
    parameter int SIZE_W = 16,
    parameter int PKT_W  = 10,
    parameter int MPS_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [SIZE_W-1:0] load_size,
    input  logic [PKT_W-1:0]  load_pkts,
    input  logic              commit,
    input  logic [MPS_W-1:0]  sent_len,
    input  logic [MPS_W-1:0]  mps,
    output logic [SIZE_W-1:0] xfer_left,
    output logic [PKT_W-1:0]  pkt_left,
    output logic              done_next
);

    logic              short_pkt;
    logic [SIZE_W-1:0] xfer_nxt;
    logic [PKT_W-1:0]  pkt_nxt;

    always_comb begin
        short_pkt = (sent_len < mps);
        xfer_nxt  = xfer_left - SIZE_W'(sent_len);
        if (short_pkt || pkt_left == '0)
            pkt_nxt = '0;
        else
            pkt_nxt = pkt_left - PKT_W'(1);
        done_next = (xfer_nxt == '0) && (pkt_nxt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xfer_left <= '0;
            pkt_left  <= '0;
        end else if (load) begin
            xfer_left <= load_size;
            pkt_left  <= load_pkts;
        end else if (commit) begin
            xfer_left <= xfer_nxt;
            pkt_left  <= pkt_nxt;
        end
    end

endmodule

// File: rtl/in_ep_irq_bank.sv
module in_ep_irq_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_evt,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] irq
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                irq[i] <= 1'b0;
            else if (set_evt[i])
                irq[i] <= 1'b1;
            else if (clr_mask[i])
                irq[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/in_ep_txspace.sv
module in_ep_txspace #(
    parameter int FIFO_WORDS = 64,
    parameter int LVL_W      = 7
) (
    input  logic [LVL_W-1:0] level,
    output logic             empty,
    output logic [LVL_W-1:0] free_words
);

    localparam logic [LVL_W-1:0] DEPTH = LVL_W'(FIFO_WORDS);

    always_comb begin
        empty = (level == '0);
        if (level >= DEPTH)
            free_words = '0;
        else
            free_words = DEPTH - level;
    end

endmodule

// File: rtl/in_ep_sequencer.sv
module in_ep_sequencer
    import in_ep_pkg::*;
#(
    parameter int  SIZE_W     = 16,
    parameter int  PKT_W      = 10,
    parameter int  MPS_W      = 7,
    parameter int  FIFO_WORDS = 64,
    localparam int LVL_W      = $clog2(FIFO_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [SIZE_W-1:0] cfg_size,
    input  logic [PKT_W-1:0]  cfg_pkts,
    input  logic [MPS_W-1:0]  cfg_mps,
    input  logic              cfg_ctrl_ep,
    input  logic              fw_enable,
    input  logic              fw_clear_nak,
    input  logic              fw_set_nak,
    input  logic [IRQ_N-1:0]  fw_irq_clr,
    input  logic              tok_in,
    input  logic              hs_ack,
    input  logic              hs_timeout,
    input  logic [LVL_W-1:0]  fifo_level,
    output logic              rsp_send,
    output logic              rsp_nak,
    output logic [MPS_W-1:0]  rsp_len,
    output logic              fifo_rewind,
    output logic              ep_active,
    output logic              ep_nak,
    output logic [SIZE_W-1:0] xfer_left,
    output logic [PKT_W-1:0]  pkt_left,
    output logic [IRQ_N-1:0]  irq,
    output logic              txf_empty,
    output logic [LVL_W-1:0]  txf_free
);

    localparam int CMP_W = (LVL_W + 2 > MPS_W) ? LVL_W + 2 : MPS_W;

    seq_state_t       state, state_nxt;
    logic             tok_idle;
    logic             serve;
    logic             have_data;
    logic [MPS_W-1:0] pkt_len;
    logic             done_next;
    logic             commit;
    logic             tmo_evt;
    logic [IRQ_N-1:0] irq_set;

    // Decision for the token seen in ST_IDLE
    always_comb begin
        if (xfer_left < SIZE_W'(cfg_mps))
            pkt_len = MPS_W'(xfer_left);
        else
            pkt_len = cfg_mps;
        have_data = (pkt_len == '0) ||
                    ({CMP_W'(fifo_level), 2'b00} >= {2'b00, CMP_W'(pkt_len)});
        tok_idle  = tok_in && (state == ST_IDLE);
        serve     = tok_idle && ep_active && !ep_nak &&
                    (pkt_left != '0) && have_data;
        commit    = (state == ST_COMMIT);
        tmo_evt   = (state == ST_WAIT_HS) && hs_timeout && !hs_ack;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nxt;
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:    if (serve) state_nxt = ST_WAIT_HS;
            ST_WAIT_HS: begin
                if (hs_ack)
                    state_nxt = ST_COMMIT;
                else if (hs_timeout)
                    state_nxt = ST_IDLE;
            end
            ST_COMMIT:  state_nxt = ST_IDLE;
            default:    state_nxt = ST_IDLE;
        endcase
    end

    // Registered outputs and endpoint status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_send    <= 1'b0;
            rsp_nak     <= 1'b0;
            rsp_len     <= '0;
            fifo_rewind <= 1'b0;
            ep_active   <= 1'b0;
            ep_nak      <= 1'b1;
        end else begin
            rsp_send    <= serve;
            rsp_nak     <= tok_idle && !serve;
            fifo_rewind <= tmo_evt;
            if (serve)
                rsp_len <= pkt_len;
            if (commit && done_next)
                ep_active <= 1'b0;
            else if (fw_enable)
                ep_active <= 1'b1;
            if (fw_set_nak)
                ep_nak <= 1'b1;
            else if (fw_clear_nak)
                ep_nak <= 1'b0;
        end
    end

    always_comb begin
        irq_set            = '0;
        irq_set[IRQ_DONE]  = commit && done_next;
        irq_set[IRQ_EMPTY] = tok_idle && (fifo_level == '0) && (pkt_left == '0);
        irq_set[IRQ_TMO]   = tmo_evt && cfg_ctrl_ep;
    end

    in_ep_counters #(
        .SIZE_W (SIZE_W),
        .PKT_W  (PKT_W),
        .MPS_W  (MPS_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cfg_load),
        .load_size (cfg_size),
        .load_pkts (cfg_pkts),
        .commit    (commit),
        .sent_len  (rsp_len),
        .mps       (cfg_mps),
        .xfer_left (xfer_left),
        .pkt_left  (pkt_left),
        .done_next (done_next)
    );

    in_ep_irq_bank #(
        .N (IRQ_N)
    ) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_evt  (irq_set),
        .clr_mask (fw_irq_clr),
        .irq      (irq)
    );

    in_ep_txspace #(
        .FIFO_WORDS (FIFO_WORDS),
        .LVL_W      (LVL_W)
    ) u_space (
        .level      (fifo_level),
        .empty      (txf_empty),
        .free_words (txf_free)
    );

endmodule

// File: rtl/in_ep_sequencer_chk.sv
module in_ep_sequencer_chk
    import in_ep_pkg::*;
#(
    parameter int SIZE_W     = 16,
    parameter int PKT_W      = 10,
    parameter int MPS_W      = 7,
    parameter int FIFO_WORDS = 64,
    parameter int LVL_W      = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tok_in,
    input logic              fw_set_nak,
    input logic [MPS_W-1:0]  cfg_mps,
    input logic [LVL_W-1:0]  fifo_level,
    input logic              rsp_send,
    input logic              rsp_nak,
    input logic [MPS_W-1:0]  rsp_len,
    input logic              fifo_rewind,
    input logic              ep_active,
    input logic              ep_nak,
    input logic [SIZE_W-1:0] xfer_left,
    input logic [PKT_W-1:0]  pkt_left,
    input logic [IRQ_N-1:0]  irq,
    input logic              txf_empty,
    input logic [LVL_W-1:0]  txf_free
);

    AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        tok_in |=> (rsp_send != rsp_nak)); // R2

    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_send |-> (rsp_len <= cfg_mps)); // R2

    AST_BLOCKED_NO_SEND: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_in && (ep_nak || !ep_active)) |=> !rsp_send); // R7

    AST_EMPTY_NAK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_in && !ep_nak && !fw_set_nak && fifo_level == '0 && pkt_left == '0)
        |=> (!ep_nak && rsp_nak && irq[IRQ_EMPTY])); // R6

    AST_DONE_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq[IRQ_DONE]) |-> !ep_active); // R5

    AST_REWIND_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rewind |-> ($stable(pkt_left) && $stable(xfer_left))); // R8

    AST_EMPTY_FULL_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        txf_empty |-> (txf_free == LVL_W'(FIFO_WORDS))); // R11

endmodule

bind in_ep_sequencer in_ep_sequencer_chk #(
    .SIZE_W     (SIZE_W),
    .PKT_W      (PKT_W),
    .MPS_W      (MPS_W),
    .FIFO_WORDS (FIFO_WORDS),
    .LVL_W      (LVL_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tok_in      (tok_in),
    .fw_set_nak  (fw_set_nak),
    .cfg_mps     (cfg_mps),
    .fifo_level  (fifo_level),
    .rsp_send    (rsp_send),
    .rsp_nak     (rsp_nak),
    .rsp_len     (rsp_len),
    .fifo_rewind (fifo_rewind),
    .ep_active   (ep_active),
    .ep_nak      (ep_nak),
    .xfer_left   (xfer_left),
    .pkt_left    (pkt_left),
    .irq         (irq),
    .txf_empty   (txf_empty),
    .txf_free    (txf_free)
);

// File: tb/in_ep_sequencer_test.sv
`timescale 1ns/1ps
module in_ep_sequencer_test;

    localparam int SIZE_W     = 16;
    localparam int PKT_W      = 10;
    localparam int MPS_W      = 7;
    localparam int FIFO_WORDS = 64;
    localparam int LVL_W      = $clog2(FIFO_WORDS + 1);

    // {fifo_level, expected txf_free, expected txf_empty}
    localparam int NVEC = 6;
    localparam int SPACE_VEC [NVEC][3] = '{
        '{0, 64, 1}, '{1, 63, 0}, '{17, 47, 0},
        '{32, 32, 0}, '{63, 1, 0}, '{64, 0, 0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_load = 1'b0;
    logic [SIZE_W-1:0] cfg_size = '0;
    logic [PKT_W-1:0]  cfg_pkts = '0;
    logic [MPS_W-1:0]  cfg_mps = 7'd64;
    logic              cfg_ctrl_ep = 1'b0;
    logic              fw_enable = 1'b0;
    logic              fw_clear_nak = 1'b0;
    logic              fw_set_nak = 1'b0;
    logic [2:0]        fw_irq_clr = '0;
    logic              tok_in = 1'b0;
    logic              hs_ack = 1'b0;
    logic              hs_timeout = 1'b0;
    logic [LVL_W-1:0]  fifo_level = '0;
    logic              rsp_send, rsp_nak, fifo_rewind, ep_active, ep_nak, txf_empty;
    logic [MPS_W-1:0]  rsp_len;
    logic [SIZE_W-1:0] xfer_left;
    logic [PKT_W-1:0]  pkt_left;
    logic [2:0]        irq;
    logic [LVL_W-1:0]  txf_free;

    int  n_run = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #4 clk = ~clk;

    in_ep_sequencer #(
        .SIZE_W(SIZE_W), .PKT_W(PKT_W), .MPS_W(MPS_W), .FIFO_WORDS(FIFO_WORDS)
    ) uut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_size(cfg_size),
        .cfg_pkts(cfg_pkts), .cfg_mps(cfg_mps), .cfg_ctrl_ep(cfg_ctrl_ep),
        .fw_enable(fw_enable), .fw_clear_nak(fw_clear_nak), .fw_set_nak(fw_set_nak),
        .fw_irq_clr(fw_irq_clr), .tok_in(tok_in), .hs_ack(hs_ack),
        .hs_timeout(hs_timeout), .fifo_level(fifo_level), .rsp_send(rsp_send),
        .rsp_nak(rsp_nak), .rsp_len(rsp_len), .fifo_rewind(fifo_rewind),
        .ep_active(ep_active), .ep_nak(ep_nak), .xfer_left(xfer_left),
        .pkt_left(pkt_left), .irq(irq), .txf_empty(txf_empty), .txf_free(txf_free)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic load(input int size, input int pkts);
        cfg_size = SIZE_W'(size);
        cfg_pkts = PKT_W'(pkts);
        cfg_load = 1'b1;
        cyc();
        cfg_load = 1'b0;
    endtask

    task automatic arm();
        fw_enable = 1'b1;
        fw_clear_nak = 1'b1;
        cyc();
        fw_enable = 1'b0;
        fw_clear_nak = 1'b0;
    endtask

    task automatic token(input int level);
        fifo_level = LVL_W'(level);
        tok_in = 1'b1;
        cyc();
        tok_in = 1'b0;
    endtask

    task automatic ack();
        hs_ack = 1'b1;
        cyc();
        hs_ack = 1'b0;
        cyc();
    endtask

    task automatic clear_irq(input logic [2:0] m);
        fw_irq_clr = m;
        cyc();
        fw_irq_clr = '0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        repeat (3) cyc();
        // R1: reset state
        check("R1", "ep_active", ep_active, 0);
        check("R1", "ep_nak", ep_nak, 1);
        check("R1", "xfer_left", xfer_left, 0);
        check("R1", "pkt_left", pkt_left, 0);
        check("R1", "irq", irq, 0);
        check("R1", "rsp", {rsp_send, rsp_nak, fifo_rewind}, 0);
        rst_n = 1'b1;
        cyc();
        check("R1", "irq after release", irq, 0);

        // R11: free-space vectors
        for (int i = 0; i < NVEC; i++) begin
            fifo_level = LVL_W'(SPACE_VEC[i][0]);
            #1;
            check("R11", "txf_free", txf_free, SPACE_VEC[i][1]);
            check("R11", "txf_empty", txf_empty, SPACE_VEC[i][2]);
        end
        cyc();

        // R2: load
        load(100, 2);
        check("R2", "xfer_left load", xfer_left, 100);
        check("R2", "pkt_left load", pkt_left, 2);

        // R7: disabled endpoint with NAK set
        token(16);
        check("R7", "nak while disabled", {rsp_send, rsp_nak}, 2'b01);
        check("R7", "xfer unchanged", xfer_left, 100);
        check("R7", "pkt unchanged", pkt_left, 2);

        arm();
        check("R2", "armed", {ep_active, ep_nak}, 2'b10);

        // R9: not enough data (32 bytes < 64)
        token(8);
        check("R9", "nak on short fifo", {rsp_send, rsp_nak}, 2'b01);
        check("R9", "no irq", irq, 0);

        // R2 / R3: full packet
        token(16);
        check("R2", "send", {rsp_send, rsp_nak}, 2'b10);
        check("R2", "len", rsp_len, 64);
        ack();
        check("R3", "xfer after ack", xfer_left, 36);
        check("R3", "pkt after ack", pkt_left, 1);
        check("R5", "still enabled", ep_active, 1);
        check("R5", "no done yet", irq[0], 0);

        // R8: timeout on a non-control endpoint
        token(16);
        check("R2", "len remainder", rsp_len, 36);
        hs_timeout = 1'b1;
        cyc();
        hs_timeout = 1'b0;
        check("R8", "rewind", fifo_rewind, 1);
        check("R8", "no tmo irq bulk", irq[2], 0);
        check("R8", "xfer kept", xfer_left, 36);
        check("R8", "pkt kept", pkt_left, 1);
        cyc();
        check("R8", "rewind pulse ends", fifo_rewind, 0);

        // R8: timeout on a control endpoint
        cfg_ctrl_ep = 1'b1;
        token(16);
        hs_timeout = 1'b1;
        cyc();
        hs_timeout = 1'b0;
        check("R8", "tmo irq ctrl", irq[2], 1);

        // R10: write-one-to-clear on a single bit
        clear_irq(3'b011);
        check("R10", "zero-mask bit kept", irq[2], 1);
        clear_irq(3'b100);
        check("R10", "cleared", irq, 0);
        cfg_ctrl_ep = 1'b0;

        // R4 / R5: short final packet completes
        token(16);
        check("R2", "len 36", rsp_len, 36);
        ack();
        check("R4", "xfer zero", xfer_left, 0);
        check("R4", "pkt zero", pkt_left, 0);
        check("R5", "done irq", irq[0], 1);
        check("R5", "disabled", ep_active, 0);

        // R6: empty-FIFO token with zero packets left
        token(0);
        check("R6", "nak", {rsp_send, rsp_nak}, 2'b01);
        check("R6", "empty irq", irq[1], 1);
        check("R6", "ep_nak stays clear", ep_nak, 0);
        clear_irq(3'b111);

        // R4: short packet forces pkt_left to zero
        load(10, 3);
        arm();
        token(4);
        check("R4", "short len", rsp_len, 10);
        ack();
        check("R4", "pkt forced zero", pkt_left, 0);
        check("R4", "done irq", irq[0], 1);
        check("R4", "disabled", ep_active, 0);
        clear_irq(3'b111);

        // R12: zero-length packet
        load(0, 1);
        arm();
        token(0);
        check("R12", "zlp send", {rsp_send, rsp_nak}, 2'b10);
        check("R12", "zlp len", rsp_len, 0);
        check("R12", "no empty irq", irq[1], 0);
        ack();
        check("R12", "pkt zero", pkt_left, 0);
        check("R5", "done after zlp", irq[0], 1);
        clear_irq(3'b111);

        // R5: two full packets
        load(128, 2);
        arm();
        token(32);
        ack();
        check("R5", "mid enabled", ep_active, 1);
        check("R5", "mid no done", irq[0], 0);
        token(32);
        ack();
        check("R5", "done", irq[0], 1);
        check("R5", "disabled", ep_active, 0);
        clear_irq(3'b111);

        // R7: NAK status set on an enabled endpoint
        load(64, 1);
        arm();
        fw_set_nak = 1'b1;
        cyc();
        fw_set_nak = 1'b0;
        token(16);
        check("R7", "nak when nak set", {rsp_send, rsp_nak}, 2'b01);
        check("R7", "pkt unchanged", pkt_left, 1);
        check("R7", "xfer unchanged", xfer_left, 64);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule